// File: doc/BRIEF.md
# Fetch-Stage Branch Target Cache

This block sits in an instruction fetch stage and guesses where a sequential fetch stream should jump next. It keeps a direct-mapped table of recently resolved simple branches: for each one it stores enough of the branch's own address to recognise it, the address the branch went to, and a valid bit. When the fetch stage arrives at a remembered taken branch, the block sends the next fetch to the stored target. It also raises a predicted-taken flag alongside that fetch, so that decode does not apply its own static guess to that instruction.

The execute stage reports every resolved simple branch through an update port, whether the branch was taken or not. A taken outcome installs the entry with its valid bit set. A not-taken outcome rewrites the entry with its valid bit cleared, so a branch that stopped being taken is no longer predicted.

The table read is registered and the compare is registered too. For this reason the lookup for an address is started two fetches in advance, at the fetch eight bytes earlier. Any break in the sequential stream throws the in-flight lookups away. Such a break is an external redirect, a predicted redirect by the block itself, or a cycle with no sequential fetch. The first two fetches after a break therefore can never be predicted.

Top module: `btc_fetch_predictor`

## Requirements
- R1: After reset every valid bit is clear, so no fetch is predicted until an update with taken set has been applied.
- R2: When no prediction is made, the next fetch address is `redirect_addr_i` if `redirect_i` is high, otherwise `fetch_addr_i + 4` if `seq_i` is high, otherwise `fetch_addr_i` unchanged.
- R3: An update (`upd_vld_i` high) always rewrites the entry selected by `upd_addr_i`. Its valid bit becomes `upd_taken_i`, so a taken branch is installed and a not-taken branch is removed.
- R4: The entry index is address bits [IDX_W+1:2]. The tag is every remaining address bit. A fetch is predicted when its entry is valid and the tag matches the fetch address. In that same cycle `next_addr_o` equals the stored target and `pred_taken_o` is 1.
- R5: `pred_taken_o` is 1 only in a cycle where a stored target is used, which requires `seq_i` high and `redirect_i` low.
- R6: The lookup for fetch address A is issued in the cycle that fetches A-8. A prediction is only possible for the third and later fetch of an unbroken sequential run. A run is broken by `redirect_i`, by the block's own prediction, or by a cycle with `seq_i` low.
- R7: `redirect_i` takes priority over a prediction in the same cycle. The next address is `redirect_addr_i` and `pred_taken_o` is 0.
- R8: If an update writes the same entry in the same cycle a lookup is issued for it, that lookup sees the contents from before the update. The update is seen by later lookups.
- R9: With the cache disabled by parameter (`USE_CACHE` = 0), the block never predicts and behaves as R2 in every cycle.
- R10: Two branches whose addresses share an index but differ in tag displace each other. Only the most recently written one can be predicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_addr_i | input | ADDR_W | Address fetched in this cycle |
| seq_i | input | 1 | A fetch takes place this cycle and the stream advances sequentially |
| redirect_i | input | 1 | Redirect request from decode or execute |
| redirect_addr_i | input | ADDR_W | Address to fetch next on a redirect |
| upd_vld_i | input | 1 | A resolved simple branch is reported this cycle |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_tgt_i | input | ADDR_W | Target address of the resolved branch |
| upd_taken_i | input | 1 | Resolved branch was taken |
| next_addr_o | output | ADDR_W | Address to fetch in the next cycle |
| pred_taken_o | output | 1 | The current fetch is redirected by the cache (predicted taken) |

## Verification
The main instance is built with a 16-entry table (IDX_W = 4) and 32-bit addresses. With only 16 entries, index aliasing and entry displacement happen within a few dozen words of address space. A short random phase therefore overwrites, clears and re-hits the same entries many times. A second instance with the cache disabled receives the same stimulus, which shows that the parameter removes every prediction while the rest of the next-address logic stays the same. The behavioural model tracks lookups as a queue of snapshots taken before each update. This makes the two-fetch blind window and the same-cycle collision ordering directly comparable against the design on every cycle.

// File: rtl/btc_pkg.sv
package btc_pkg;

  localparam int unsigned INSN_BYTES     = 4;
  // lookup runs two fetches ahead of use
  localparam int unsigned LOOKAHEAD_BYTES = 2 * INSN_BYTES;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_SEQ   = 2'd1,
    SRC_PRED  = 2'd2,
    SRC_REDIR = 2'd3
  } next_src_e;

endpackage

// File: rtl/btc_store.sv
module btc_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  localparam int unsigned TAG_W = ADDR_W - IDX_W,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_tgt_i,
  input  logic              wr_set_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [ADDR_W-1:0] rd_tgt_o
);

  localparam int unsigned ENT_W = TAG_W + ADDR_W;

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] vbit_q;
  logic [ENT_W-1:0] rd_q;
  logic             rd_vld_q;

  // read-before-write: a same-cycle lookup sees old contents
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_q <= mem_q[rd_idx_i];
    if (wr_en_i) mem_q[wr_idx_i] <= {wr_tag_i, wr_tgt_i};
  end

  // valid bits live in flops so reset can clear them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbit_q   <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= rd_en_i & vbit_q[rd_idx_i];
      if (wr_en_i) vbit_q[wr_idx_i] <= wr_set_i;
    end
  end

  assign rd_vld_o = rd_vld_q;
  assign rd_tag_o = rd_q[ENT_W-1:ADDR_W];
  assign rd_tgt_o = rd_q[ADDR_W-1:0];

endmodule

// File: rtl/btc_lookup.sv
module btc_lookup #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              seq_i,
  input  logic              redirect_i,
  input  logic              rd_vld_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [ADDR_W-1:0] rd_tgt_i,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] hit_tgt_o
);

  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(btc_pkg::LOOKAHEAD_BYTES);

  logic [ADDR_W-1:0] look_addr;
  logic              go;

  logic              s1_vld_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [TAG_W-1:0]  s1_tag;

  logic              s2_vld_q;
  logic              s2_hit_q;
  logic [ADDR_W-1:0] s2_addr_q;
  logic [ADDR_W-1:0] s2_tgt_q;

  assign look_addr = fetch_addr_i + AHEAD;
  // stream continues past this fetch: in-flight lookups stay useful
  assign go        = seq_i & ~redirect_i & ~hit_o;

  assign rd_en_o   = go;
  assign rd_idx_o  = look_addr[IDX_W+1:2];
  assign s1_tag    = {s1_addr_q[ADDR_W-1:IDX_W+2], s1_addr_q[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_addr_q <= '0;
      s2_vld_q  <= 1'b0;
      s2_hit_q  <= 1'b0;
      s2_addr_q <= '0;
      s2_tgt_q  <= '0;
    end else begin
      s1_vld_q  <= go;
      s1_addr_q <= look_addr;
      s2_vld_q  <= s1_vld_q & go;
      s2_hit_q  <= rd_vld_i && (rd_tag_i == s1_tag);
      s2_addr_q <= s1_addr_q;
      s2_tgt_q  <= rd_tgt_i;
    end
  end

  assign hit_o     = s2_vld_q & s2_hit_q & seq_i & ~redirect_i &
                     (s2_addr_q == fetch_addr_i);
  assign hit_tgt_o = s2_tgt_q;

  // R6: first fetch after a break is blind
  a_r6_blind_after_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !hit_o);
  // R6: second fetch after a redirect is blind too
  a_r6_blind_second_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i ##1 1'b1 |=> !hit_o);
  // R6: own prediction breaks the run
  a_r6_blind_after_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
  // R6: idle cycle breaks the run
  a_r6_blind_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_i |=> !hit_o);

endmodule

// File: rtl/btc_next.sv
module btc_next #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              seq_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_addr_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] hit_tgt_i,
  output logic [ADDR_W-1:0] next_addr_o
);

  import btc_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  next_src_e sel;

  always_comb begin
    sel = SRC_HOLD;
    if (redirect_i)  sel = SRC_REDIR;
    else if (hit_i)  sel = SRC_PRED;
    else if (seq_i)  sel = SRC_SEQ;
  end

  always_comb begin
    case (sel)
      SRC_REDIR: next_addr_o = redirect_addr_i;
      SRC_PRED:  next_addr_o = hit_tgt_i;
      SRC_SEQ:   next_addr_o = fetch_addr_i + STEP;
      default:   next_addr_o = fetch_addr_i;
    endcase
  end

endmodule

// File: rtl/btc_fetch_predictor.sv
module btc_fetch_predictor #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 10,
  parameter bit          USE_CACHE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              seq_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_addr_i,
  input  logic              upd_vld_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [ADDR_W-1:0] upd_tgt_i,
  input  logic              upd_taken_i,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic              pred_taken_o
);

  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic              hit;
  logic [ADDR_W-1:0] hit_tgt;

  if (USE_CACHE) begin : g_cache
    logic              rd_en;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_vld;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_tgt;
    logic [TAG_W-1:0]  upd_tag;

    // tag keeps every address bit outside the index
    assign upd_tag = {upd_addr_i[ADDR_W-1:IDX_W+2], upd_addr_i[1:0]};

    btc_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_en_i  (rd_en),
      .rd_idx_i (rd_idx),
      .wr_en_i  (upd_vld_i),
      .wr_idx_i (upd_addr_i[IDX_W+1:2]),
      .wr_tag_i (upd_tag),
      .wr_tgt_i (upd_tgt_i),
      .wr_set_i (upd_taken_i),
      .rd_vld_o (rd_vld),
      .rd_tag_o (rd_tag),
      .rd_tgt_o (rd_tgt)
    );

    btc_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fetch_addr_i (fetch_addr_i),
      .seq_i        (seq_i),
      .redirect_i   (redirect_i),
      .rd_vld_i     (rd_vld),
      .rd_tag_i     (rd_tag),
      .rd_tgt_i     (rd_tgt),
      .rd_en_o      (rd_en),
      .rd_idx_o     (rd_idx),
      .hit_o        (hit),
      .hit_tgt_o    (hit_tgt)
    );
  end else begin : g_bypass
    assign hit     = 1'b0;
    assign hit_tgt = '0;
  end

  btc_next #(.ADDR_W(ADDR_W)) u_next (
    .fetch_addr_i    (fetch_addr_i),
    .seq_i           (seq_i),
    .redirect_i      (redirect_i),
    .redirect_addr_i (redirect_addr_i),
    .hit_i           (hit),
    .hit_tgt_i       (hit_tgt),
    .next_addr_o     (next_addr_o)
  );

  assign pred_taken_o = hit;

  // R5: a predicted fetch needs a live sequential stream
  a_r5_pred_needs_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> (seq_i && !redirect_i));

endmodule

// File: tb/sim_btc_fetch_predictor.sv
module sim_btc_fetch_predictor;

  localparam int AW   = 32;
  localparam int IW   = 4;
  localparam int NENT = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] fetch_addr = '0, redirect_addr = '0, upd_addr = '0, upd_tgt = '0;
  logic          seq = 1'b0, redirect = 1'b0, upd_vld = 1'b0, upd_taken = 1'b0;
  logic [AW-1:0] next0, next1;
  logic          pred0, pred1;

  always #5 clk = ~clk;

  btc_fetch_predictor #(.ADDR_W(AW), .IDX_W(IW), .USE_CACHE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_addr_i(fetch_addr), .seq_i(seq),
    .redirect_i(redirect), .redirect_addr_i(redirect_addr), .upd_vld_i(upd_vld),
    .upd_addr_i(upd_addr), .upd_tgt_i(upd_tgt), .upd_taken_i(upd_taken),
    .next_addr_o(next0), .pred_taken_o(pred0));

  btc_fetch_predictor #(.ADDR_W(AW), .IDX_W(IW), .USE_CACHE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_addr_i(fetch_addr), .seq_i(seq),
    .redirect_i(redirect), .redirect_addr_i(redirect_addr), .upd_vld_i(upd_vld),
    .upd_addr_i(upd_addr), .upd_tgt_i(upd_tgt), .upd_taken_i(upd_taken),
    .next_addr_o(next1), .pred_taken_o(pred1));

  int n_chk = 0, n_fail = 0, n_hit = 0;

  typedef struct {
    bit            hit;
    logic [AW-1:0] addr;
    logic [AW-1:0] tgt;
  } look_t;

  look_t         pend[$];
  bit            ref_vld[NENT];
  logic [AW-1:0] ref_br[NENT];
  logic [AW-1:0] ref_tg[NENT];
  logic [AW-1:0] pc = '0;

  task automatic check(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one fetch cycle: drive, compare against the model, advance the model
  task automatic cyc(bit sq, bit rd, logic [AW-1:0] ra, bit uv, logic [AW-1:0] ua,
                     logic [AW-1:0] ut, bit utk, string req);
    bit            eh;
    logic [AW-1:0] en, la;
    int            li;
    look_t         nl;
    @(negedge clk);
    fetch_addr = pc; seq = sq; redirect = rd; redirect_addr = ra;
    upd_vld = uv; upd_addr = ua; upd_tgt = ut; upd_taken = utk;
    #1;
    eh = sq && !rd && pend.size() == 2 && pend[0].hit && pend[0].addr == pc;
    en = rd ? ra : eh ? pend[0].tgt : sq ? pc + 4 : pc;
    if (eh) n_hit++;
    check(req, "pred_taken", {31'd0, pred0}, {31'd0, eh});
    check(req, "next_addr", next0, en);
    check("R9", "next_addr disabled", next1, rd ? ra : sq ? pc + 4 : pc);
    check("R9", "pred_taken disabled", {31'd0, pred1}, 32'd0);
    // lookup snapshot for pc+8, taken before this cycle's update (R8)
    la = pc + 8;
    li = int'(la[IW+1:2]);
    nl.hit  = ref_vld[li] && ref_br[li] == la;
    nl.addr = la;
    nl.tgt  = ref_tg[li];
    if (sq && !rd && !eh) begin
      if (pend.size() == 2) void'(pend.pop_front());
      pend.push_back(nl);
    end else begin
      pend.delete();
    end
    if (uv) begin
      li = int'(ua[IW+1:2]);
      ref_br[li] = ua; ref_tg[li] = ut; ref_vld[li] = utk;
    end
    pc = en;
  endtask

  task automatic seqn(int n, string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic jump(logic [AW-1:0] a, string req);
    cyc(1'b1, 1'b1, a, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic learn(logic [AW-1:0] a, logic [AW-1:0] t, bit tk, string req);
    cyc(1'b1, 1'b0, '0, 1'b1, a, t, tk, req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int h0;
    for (int i = 0; i < NENT; i++) begin
      ref_vld[i] = 1'b0; ref_br[i] = '0; ref_tg[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: reset state, nothing predicted from an empty table
    cyc(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, "R1");
    seqn(40, "R1");
    check("R1", "hits after reset", n_hit, 0);

    // R2: hold, sequential and redirect paths
    cyc(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, "R2");
    cyc(1'b0, 1'b1, 32'h0000_0200, 1'b0, '0, '0, 1'b0, "R2");

    // R3/R4: install 0x100 -> 0x300 and run into it
    learn(32'h0000_0100, 32'h0000_0300, 1'b1, "R3");
    h0 = n_hit;
    jump(32'h0000_00F0, "R4");
    seqn(8, "R4");
    check("R4", "hit count on installed branch", n_hit - h0, 1);

    // R6: blind window after a redirect
    h0 = n_hit;
    jump(32'h0000_0100, "R6");
    seqn(2, "R6");
    jump(32'h0000_00FC, "R6");
    seqn(3, "R6");
    check("R6", "hits inside blind window", n_hit - h0, 0);
    jump(32'h0000_00F8, "R6");
    seqn(4, "R6");
    check("R6", "hit on third fetch", n_hit - h0, 1);

    // R7: redirect beats a prediction in the same cycle
    h0 = n_hit;
    jump(32'h0000_00F8, "R7");
    seqn(2, "R7");
    cyc(1'b1, 1'b1, 32'h0000_0800, 1'b0, '0, '0, 1'b0, "R7");
    check("R7", "hits under redirect", n_hit - h0, 0);

    // R10: alias at same index displaces the older branch
    learn(32'h0000_0140, 32'h0000_0380, 1'b1, "R10");
    h0 = n_hit;
    jump(32'h0000_00F8, "R10");
    seqn(20, "R10");
    check("R10", "only aliasing branch hits", n_hit - h0, 1);

    // R8: same-cycle update and lookup of one entry
    learn(32'h0000_0100, 32'h0000_0300, 1'b1, "R8");
    h0 = n_hit;
    jump(32'h0000_00F8, "R8");
    cyc(1'b1, 1'b0, '0, 1'b1, 32'h0000_0100, 32'h0000_0300, 1'b0, "R8");
    seqn(3, "R8");
    check("R8", "lookup saw old contents", n_hit - h0, 1);
    // R3: not-taken update removed it
    h0 = n_hit;
    jump(32'h0000_00F8, "R3");
    seqn(6, "R3");
    check("R3", "cleared entry not predicted", n_hit - h0, 0);

    // R6: idle cycle breaks the run
    learn(32'h0000_0100, 32'h0000_0300, 1'b1, "R6");
    h0 = n_hit;
    jump(32'h0000_00F4, "R6");
    seqn(2, "R6");
    cyc(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, "R6");
    seqn(2, "R6");
    check("R6", "no hit after idle gap", n_hit - h0, 0);

    // mixed random traffic in a small region, heavy aliasing
    h0 = n_hit;
    jump(32'h0000_0000, "R6");
    for (int i = 0; i < 4000; i++) begin
      bit            sq, rd, uv, tk;
      logic [AW-1:0] ra, ua, ut;
      sq = ($urandom % 100) < 93;
      rd = ($urandom % 100) < 7;
      ra = AW'(($urandom % 256) * 4);
      uv = ($urandom % 100) < 35;
      ua = ($urandom % 2) ? pc + AW'(($urandom % 12) * 4) : AW'(($urandom % 256) * 4);
      ut = AW'(($urandom % 256) * 4);
      tk = ($urandom % 4) != 0;
      cyc(sq, rd, ra, uv, ua, ut, tk, "R6");
    end
    n_chk++;
    if (n_hit - h0 == 0) begin
      n_fail++;
      $display("FAIL R4 random hits: actual 0 expected nonzero");
    end

    summary();
    $finish;
  end

endmodule